// File: doc/BRIEF.md
# Extended 16-bit Bit-Slice ALU

This block is one 16-bit slice of a microprogrammed datapath. It holds a 64-word by 16-bit register file with two read ports, a Q working register, an eight-function ALU and an operand selector. Shifters move data up or down on the register-file write path and on the Q path. Each clock cycle a 10-bit microinstruction picks the operand pair, the ALU function and the destination.

The low six bits of the microinstruction choose the operands and the function. Bits 8..6 choose the destination and bit 9 selects one of two destination sets. With bit 9 high, the familiar bit-slice destinations apply. With bit 9 low, the register file takes the D input directly at the B address, bypassing the ALU, while the ALU result can go to Q and to Y in the same cycle. Carry, overflow, generate and propagate outputs let a second slice extend the word to 32 bits through a carry chain.

Top module: `bitslice_alu16`

## Requirements
- R1: Reset (rstN low, asynchronous) clears Q and every register-file word to zero.
- R2: Operand pair (R,S) is chosen by instr[2:0]: 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0). A and B are the file words at aAddr and bAddr.
- R3: instr[5:3] selects F: 0=R+S+cin, 1=~R+S+cin, 2=R+~S+cin, 3=R|S, 4=R&S, 5=~R&S, 6=R^S, 7=~(R^S). carryOut is the carry out of bit 15 for codes 0..2 and 0 for codes 3..7.
- R4: overflow is the XOR of the carries into and out of bit 15 for codes 0..2 (0 otherwise). sign equals F[15]. zero is 1 exactly when F is all zeros.
- R5: For codes 0..2, gen is the carry out of the two ALU addends with no carry-in and prop is the AND of their bitwise XOR, so carryOut = gen | (prop & carryIn). Both are 0 for logic codes.
- R6: With instr[9]=1, instr[8:6] gives: 0 Q<=F; 1 no write; 2 file<=F with Y=A; 3 file<=F; 4 file<=F>>1 and Q<=Q>>1; 5 file<=F>>1; 6 file<=F<<1 and Q<=Q<<1; 7 file<=F<<1. The file is written at bAddr.
- R7: On a down shift the top bit enters from the high pin input (ramHiIn, qHiIn) and bit 0 leaves on the low pin output, whose enable is high. On an up shift bit 0 enters from the low pin input and bit 15 leaves on the high pin output, whose enable is high. An enable is high only in its active shift direction.
- R8: With instr[9]=0, instr[8:6] gives: 0 file<=D and Q<=F; 1 file<=D; 2 file<=D, Q<=F and Y=A; 3 file<=D and Y=A; 4 Q<=Q>>1; 5 file<=D and Q<=Q>>1; 6 Q<=Q<<1; 7 file<=D and Q<=Q<<1. These modes use the same pin rules as R7.
- R9: yBus shows A in the modes marked Y=A and shows F otherwise. When outEn is low, yBus reads all zeros.
- R10: When a read and a write hit the same address in one cycle, the read returns the old word. The new word is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aAddr | input | 6 | Register file read address A |
| bAddr | input | 6 | Register file read address B and write address |
| dIn | input | 16 | Direct data input |
| carryIn | input | 1 | ALU carry-in |
| instr | input | 10 | Microinstruction |
| outEn | input | 1 | Y output enable |
| ramLoIn | input | 1 | File shifter low-end input |
| ramHiIn | input | 1 | File shifter high-end input |
| qLoIn | input | 1 | Q shifter low-end input |
| qHiIn | input | 1 | Q shifter high-end input |
| yBus | output | 16 | Y output |
| carryOut | output | 1 | ALU carry-out |
| gen | output | 1 | Group generate |
| prop | output | 1 | Group propagate |
| overflow | output | 1 | Signed overflow |
| sign | output | 1 | F bit 15 |
| zero | output | 1 | F all zeros |
| ramLoOut | output | 1 | File shifter low-end output |
| ramLoOe | output | 1 | Drive enable for ramLoOut |
| ramHiOut | output | 1 | File shifter high-end output |
| ramHiOe | output | 1 | Drive enable for ramHiOut |
| qLoOut | output | 1 | Q shifter low-end output |
| qLoOe | output | 1 | Drive enable for qLoOut |
| qHiOut | output | 1 | Q shifter high-end output |
| qHiOe | output | 1 | Drive enable for qHiOut |

## Verification
The properties assume only that the microinstruction, addresses and pin inputs are stable, known values at each rising edge. No combination of them is illegal: every opcode, address pair and shift-pin value is a defined case. The stimulus changes inputs only at the falling edge and draws all fields from the full range, so same-address read/write and every destination code in both sets occur. Directed steps add reset readback, signed overflow, zero results and disabled output.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;
  typedef enum logic [1:0] {RW_F, RW_DN, RW_UP, RW_D} ramSrc_e;
  typedef enum logic [1:0] {QH_HOLD, QH_F, QH_DN, QH_UP} qSrc_e;

  typedef struct packed {
    logic    ramWe;
    ramSrc_e ramSrc;
    qSrc_e   qSrc;
    logic    yFromA;
  } destCtl_t;
endpackage

// File: rtl/bsalu_ctrl.sv
module bsalu_ctrl
  import bsalu_pkg::*;
(
  input  logic [3:0] destCode,
  output destCtl_t   ctl
);
  always_comb begin
    ctl = '{ramWe: 1'b0, ramSrc: RW_F, qSrc: QH_HOLD, yFromA: 1'b0};
    if (destCode[3]) begin
      // classic destination set
      case (destCode[2:0])
        3'd0: ctl.qSrc = QH_F;
        3'd1: ;
        3'd2: begin ctl.ramWe = 1'b1; ctl.yFromA = 1'b1; end
        3'd3: ctl.ramWe = 1'b1;
        3'd4: begin ctl.ramWe = 1'b1; ctl.ramSrc = RW_DN; ctl.qSrc = QH_DN; end
        3'd5: begin ctl.ramWe = 1'b1; ctl.ramSrc = RW_DN; end
        3'd6: begin ctl.ramWe = 1'b1; ctl.ramSrc = RW_UP; ctl.qSrc = QH_UP; end
        default: begin ctl.ramWe = 1'b1; ctl.ramSrc = RW_UP; end
      endcase
    end else begin
      // extended set: file loads D directly, in parallel with the ALU
      ctl.ramSrc = RW_D;
      case (destCode[2:0])
        3'd0: begin ctl.ramWe = 1'b1; ctl.qSrc = QH_F; end
        3'd1: ctl.ramWe = 1'b1;
        3'd2: begin ctl.ramWe = 1'b1; ctl.qSrc = QH_F; ctl.yFromA = 1'b1; end
        3'd3: begin ctl.ramWe = 1'b1; ctl.yFromA = 1'b1; end
        3'd4: ctl.qSrc = QH_DN;
        3'd5: begin ctl.ramWe = 1'b1; ctl.qSrc = QH_DN; end
        3'd6: ctl.qSrc = QH_UP;
        default: begin ctl.ramWe = 1'b1; ctl.qSrc = QH_UP; end
      endcase
    end
  end
endmodule

// File: rtl/bsalu_dp.sv
module bsalu_dp
  import bsalu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    aAddr,
  input  logic [AW-1:0]    bAddr,
  input  logic [WIDTH-1:0] dIn,
  input  logic             carryIn,
  input  logic [2:0]       srcSel,
  input  logic [2:0]       fnSel,
  input  destCtl_t         ctl,
  input  logic             ramLoIn,
  input  logic             ramHiIn,
  input  logic             qLoIn,
  input  logic             qHiIn,
  output logic [WIDTH-1:0] aData,
  output logic [WIDTH-1:0] fVal,
  output logic [WIDTH-1:0] qVal,
  output logic             cout,
  output logic             ovr,
  output logic             gen,
  output logic             prop,
  output logic             ramLoOut,
  output logic             ramLoOe,
  output logic             ramHiOut,
  output logic             ramHiOe,
  output logic             qLoOut,
  output logic             qLoOe,
  output logic             qHiOut,
  output logic             qHiOe
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] qReg, bData, rOp, sOp, xOp, yOp, ramWr, qNext;
  logic [WIDTH:0]   sumFull, genSum;
  logic [WIDTH-1:0] lowSum;
  logic             isArith;

  assign aData = mem[aAddr];
  assign bData = mem[bAddr];
  assign qVal  = qReg;

  always_comb begin
    case (srcSel)
      3'd0: begin rOp = aData; sOp = qReg;  end
      3'd1: begin rOp = aData; sOp = bData; end
      3'd2: begin rOp = '0;    sOp = qReg;  end
      3'd3: begin rOp = '0;    sOp = bData; end
      3'd4: begin rOp = '0;    sOp = aData; end
      3'd5: begin rOp = dIn;   sOp = aData; end
      3'd6: begin rOp = dIn;   sOp = qReg;  end
      default: begin rOp = dIn; sOp = '0;   end
    endcase
  end

  assign isArith = (fnSel <= 3'd2);
  assign xOp     = (fnSel == 3'd1) ? ~rOp : rOp;
  assign yOp     = (fnSel == 3'd2) ? ~sOp : sOp;
  assign sumFull = {1'b0, xOp} + {1'b0, yOp} + {{WIDTH{1'b0}}, carryIn};
  assign lowSum  = {1'b0, xOp[WIDTH-2:0]} + {1'b0, yOp[WIDTH-2:0]}
                 + {{(WIDTH-1){1'b0}}, carryIn};
  assign genSum  = {1'b0, xOp} + {1'b0, yOp};

  always_comb begin
    case (fnSel)
      3'd0, 3'd1, 3'd2: fVal = sumFull[WIDTH-1:0];
      3'd3: fVal = rOp | sOp;
      3'd4: fVal = rOp & sOp;
      3'd5: fVal = ~rOp & sOp;
      3'd6: fVal = rOp ^ sOp;
      default: fVal = ~(rOp ^ sOp);
    endcase
  end

  assign cout = isArith & sumFull[WIDTH];
  assign ovr  = isArith & (sumFull[WIDTH] ^ lowSum[WIDTH-1]);
  assign gen  = isArith & genSum[WIDTH];
  assign prop = isArith & (&(xOp ^ yOp));

  always_comb begin
    case (ctl.ramSrc)
      RW_F:    ramWr = fVal;
      RW_DN:   ramWr = {ramHiIn, fVal[WIDTH-1:1]};
      RW_UP:   ramWr = {fVal[WIDTH-2:0], ramLoIn};
      default: ramWr = dIn;
    endcase
    case (ctl.qSrc)
      QH_F:    qNext = fVal;
      QH_DN:   qNext = {qHiIn, qReg[WIDTH-1:1]};
      QH_UP:   qNext = {qReg[WIDTH-2:0], qLoIn};
      default: qNext = qReg;
    endcase
  end

  assign ramLoOe  = ctl.ramWe && (ctl.ramSrc == RW_DN);
  assign ramHiOe  = ctl.ramWe && (ctl.ramSrc == RW_UP);
  assign ramLoOut = ramLoOe & fVal[0];
  assign ramHiOut = ramHiOe & fVal[WIDTH-1];
  assign qLoOe    = (ctl.qSrc == QH_DN);
  assign qHiOe    = (ctl.qSrc == QH_UP);
  assign qLoOut   = qLoOe & qReg[0];
  assign qHiOut   = qHiOe & qReg[WIDTH-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (ctl.ramWe) begin
      mem[bAddr] <= ramWr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) qReg <= '0;
    else       qReg <= qNext;
  end
endmodule

// File: rtl/bitslice_alu16.sv
module bitslice_alu16
  import bsalu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    aAddr,
  input  logic [AW-1:0]    bAddr,
  input  logic [WIDTH-1:0] dIn,
  input  logic             carryIn,
  input  logic [9:0]       instr,
  input  logic             outEn,
  input  logic             ramLoIn,
  input  logic             ramHiIn,
  input  logic             qLoIn,
  input  logic             qHiIn,
  output logic [WIDTH-1:0] yBus,
  output logic             carryOut,
  output logic             gen,
  output logic             prop,
  output logic             overflow,
  output logic             sign,
  output logic             zero,
  output logic             ramLoOut,
  output logic             ramLoOe,
  output logic             ramHiOut,
  output logic             ramHiOe,
  output logic             qLoOut,
  output logic             qLoOe,
  output logic             qHiOut,
  output logic             qHiOe
);
  destCtl_t         ctl;
  logic [WIDTH-1:0] aData, fVal, qVal;

  bsalu_ctrl i_ctrl (.destCode(instr[9:6]), .ctl(ctl));

  bsalu_dp #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .aAddr(aAddr), .bAddr(bAddr), .dIn(dIn),
    .carryIn(carryIn), .srcSel(instr[2:0]), .fnSel(instr[5:3]), .ctl(ctl),
    .ramLoIn(ramLoIn), .ramHiIn(ramHiIn), .qLoIn(qLoIn), .qHiIn(qHiIn),
    .aData(aData), .fVal(fVal), .qVal(qVal),
    .cout(carryOut), .ovr(overflow), .gen(gen), .prop(prop),
    .ramLoOut(ramLoOut), .ramLoOe(ramLoOe), .ramHiOut(ramHiOut), .ramHiOe(ramHiOe),
    .qLoOut(qLoOut), .qLoOe(qLoOe), .qHiOut(qHiOut), .qHiOe(qHiOe)
  );

  assign yBus = !outEn ? '0 : (ctl.yFromA ? aData : fVal);
  assign sign = fVal[WIDTH-1];
  assign zero = (fVal == '0);
endmodule

// File: rtl/bsalu_chk.sv
module bsalu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic [9:0]   instr,
  input logic         outEn,
  input logic         carryIn,
  input logic [W-1:0] yBus,
  input logic         zero,
  input logic         cout,
  input logic         gen,
  input logic         prop,
  input logic         ramLoOe,
  input logic         ramHiOe,
  input logic         qLoOe,
  input logic         qHiOe,
  input logic [W-1:0] qNow,
  input logic [W-1:0] fNow
);
  logic yShowsF;
  assign yShowsF = (instr[9:6] != 4'b1010) && (instr[9:6] != 4'b0010)
                && (instr[9:6] != 4'b0011);

  // R7
  ram_pin_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ramLoOe && ramHiOe));

  // R7
  q_pin_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(qLoOe && qHiOe));

  // R5
  cascade_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instr[5:3] <= 3'd2) |-> (cout == (gen | (prop & carryIn))));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outEn && yShowsF) |-> (zero == (yBus == '0)));

  // R9
  y_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> (yBus == '0));

  // R6
  q_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instr[9:6] == 4'b1000) |=> (qNow == $past(fNow)));

  // R6
  q_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instr[9:6] == 4'b1001) |=> $stable(qNow));

  // R8
  ext_q_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instr[9:6] == 4'b0000) |=> (qNow == $past(fNow)));
endmodule

bind bitslice_alu16 bsalu_chk #(.W(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .instr(instr), .outEn(outEn), .carryIn(carryIn),
  .yBus(yBus), .zero(zero), .cout(carryOut), .gen(gen), .prop(prop),
  .ramLoOe(ramLoOe), .ramHiOe(ramHiOe), .qLoOe(qLoOe), .qHiOe(qHiOe),
  .qNow(qVal), .fNow(fVal)
);

// File: tb/test_bitslice_alu16.sv
module test_bitslice_alu16;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  aAddr = '0, bAddr = '0;
  logic [15:0] dIn = '0;
  logic        carryIn = 1'b0, outEn = 1'b1;
  logic [9:0]  instr = 10'b1001_011_100;
  logic        ramLoIn = 1'b0, ramHiIn = 1'b0, qLoIn = 1'b0, qHiIn = 1'b0;
  logic [15:0] yBus;
  logic carryOut, gen, prop, overflow, sign, zero;
  logic ramLoOut, ramLoOe, ramHiOut, ramHiOe, qLoOut, qLoOe, qHiOut, qHiOe;

  bitslice_alu16 i_bitslice_alu16 (
    .clk(clk), .rstN(rstN), .aAddr(aAddr), .bAddr(bAddr), .dIn(dIn),
    .carryIn(carryIn), .instr(instr), .outEn(outEn),
    .ramLoIn(ramLoIn), .ramHiIn(ramHiIn), .qLoIn(qLoIn), .qHiIn(qHiIn),
    .yBus(yBus), .carryOut(carryOut), .gen(gen), .prop(prop),
    .overflow(overflow), .sign(sign), .zero(zero),
    .ramLoOut(ramLoOut), .ramLoOe(ramLoOe), .ramHiOut(ramHiOut), .ramHiOe(ramHiOe),
    .qLoOut(qLoOut), .qLoOe(qLoOe), .qHiOut(qHiOut), .qHiOe(qHiOe)
  );

  always #4 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  logic [15:0] mRam [64];
  logic [15:0] mQ;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one microcycle: drive after the falling edge, check combinational outputs, update model
  task automatic step(input logic [9:0] ins, input logic [5:0] a, input logic [5:0] b,
                      input logic [15:0] d, input logic ci, input logic oe,
                      input logic [3:0] sh, input string tag);
    logic [15:0] av, bv, r, s, x, y, f, wv, qn, ey;
    logic [16:0] sum, gs;
    logic ar, co, ov, gn, pr, we, ya, rLoE, rHiE, qLoE, qHiE;
    @(negedge clk);
    instr = ins; aAddr = a; bAddr = b; dIn = d; carryIn = ci; outEn = oe;
    {ramLoIn, ramHiIn, qLoIn, qHiIn} = sh;
    #1;
    av = mRam[a]; bv = mRam[b];
    case (ins[2:0])
      3'd0: begin r = av;  s = mQ;  end
      3'd1: begin r = av;  s = bv;  end
      3'd2: begin r = 0;   s = mQ;  end
      3'd3: begin r = 0;   s = bv;  end
      3'd4: begin r = 0;   s = av;  end
      3'd5: begin r = d;   s = av;  end
      3'd6: begin r = d;   s = mQ;  end
      default: begin r = d; s = 0;  end
    endcase
    ar = ins[5:3] < 3;
    x = (ins[5:3] == 1) ? ~r : r;
    y = (ins[5:3] == 2) ? ~s : s;
    sum = 17'(x) + 17'(y) + 17'(ci);
    gs  = 17'(x) + 17'(y);
    case (ins[5:3])
      3'd3: f = r | s;
      3'd4: f = r & s;
      3'd5: f = ~r & s;
      3'd6: f = r ^ s;
      3'd7: f = ~(r ^ s);
      default: f = sum[15:0];
    endcase
    co = ar && sum[16];
    ov = ar && (x[15] == y[15]) && (f[15] != x[15]);
    gn = ar && gs[16];
    pr = ar && (x ^ y) == 16'hFFFF;
    we = 0; wv = 0; qn = mQ; ya = 0; rLoE = 0; rHiE = 0; qLoE = 0; qHiE = 0;
    case (ins[9:6])
      4'b1000: qn = f;
      4'b1001: ;
      4'b1010: begin we = 1; wv = f; ya = 1; end
      4'b1011: begin we = 1; wv = f; end
      4'b1100: begin we = 1; wv = {sh[2], f[15:1]}; qn = {sh[0], mQ[15:1]}; rLoE = 1; qLoE = 1; end
      4'b1101: begin we = 1; wv = {sh[2], f[15:1]}; rLoE = 1; end
      4'b1110: begin we = 1; wv = {f[14:0], sh[3]}; qn = {mQ[14:0], sh[1]}; rHiE = 1; qHiE = 1; end
      4'b1111: begin we = 1; wv = {f[14:0], sh[3]}; rHiE = 1; end
      4'b0000: begin we = 1; wv = d; qn = f; end
      4'b0001: begin we = 1; wv = d; end
      4'b0010: begin we = 1; wv = d; qn = f; ya = 1; end
      4'b0011: begin we = 1; wv = d; ya = 1; end
      4'b0100: begin qn = {sh[0], mQ[15:1]}; qLoE = 1; end
      4'b0101: begin we = 1; wv = d; qn = {sh[0], mQ[15:1]}; qLoE = 1; end
      4'b0110: begin qn = {mQ[14:0], sh[1]}; qHiE = 1; end
      default: begin we = 1; wv = d; qn = {mQ[14:0], sh[1]}; qHiE = 1; end
    endcase
    ey = !oe ? 16'h0 : (ya ? av : f);
    chk({tag, " R3 R9 y"}, 32'(yBus), 32'(ey));
    chk("R3 carryOut", 32'(carryOut), 32'(co));
    chk("R4 overflow", 32'(overflow), 32'(ov));
    chk("R4 sign", 32'(sign), 32'(f[15]));
    chk("R4 zero", 32'(zero), 32'(f == 0));
    chk("R5 gen/prop", 32'({gen, prop}), 32'({gn, pr}));
    chk({tag, " R7 pin enables"}, 32'({ramLoOe, ramHiOe, qLoOe, qHiOe}),
        32'({rLoE, rHiE, qLoE, qHiE}));
    if (rLoE) chk("R7 ramLoOut", 32'(ramLoOut), 32'(f[0]));
    if (rHiE) chk("R7 ramHiOut", 32'(ramHiOut), 32'(f[15]));
    if (qLoE) chk("R7 qLoOut", 32'(qLoOut), 32'(mQ[0]));
    if (qHiE) chk("R7 qHiOut", 32'(qHiOut), 32'(mQ[15]));
    if (we) mRam[b] = wv;
    mQ = qn;
  endtask

  initial begin
    #800000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd4242);
    for (int i = 0; i < 64; i++) mRam[i] = '0;
    mQ = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state readback through (0,A) OR and (0,Q) OR
    step(10'b1001_011_100, 6'd0,  6'd0, 16'h0, 1'b0, 1'b1, 4'h0, "R1");
    step(10'b1001_011_100, 6'd37, 6'd0, 16'h0, 1'b0, 1'b1, 4'h0, "R1");
    step(10'b1001_011_100, 6'd63, 6'd0, 16'h0, 1'b0, 1'b1, 4'h0, "R1");
    step(10'b1001_011_010, 6'd0,  6'd0, 16'h0, 1'b0, 1'b1, 4'h0, "R1");
    // R8: direct D loads into the file
    step(10'b0001_011_100, 6'd0, 6'd1, 16'h7FFF, 1'b0, 1'b1, 4'h0, "R8");
    step(10'b0001_011_100, 6'd1, 6'd2, 16'h0001, 1'b0, 1'b1, 4'h0, "R8");
    // R4: signed overflow 7FFF + 0001, then R-S with equal operands -> zero
    step(10'b1001_000_001, 6'd1, 6'd2, 16'h0, 1'b0, 1'b1, 4'h0, "R4");
    step(10'b1001_010_001, 6'd1, 6'd1, 16'h0, 1'b1, 1'b1, 4'h0, "R4");
    // R10: same-address read/write returns old, new word visible next cycle
    step(10'b0011_011_100, 6'd5, 6'd5, 16'hBEEF, 1'b0, 1'b1, 4'h0, "R10");
    step(10'b1001_011_100, 6'd5, 6'd0, 16'h0, 1'b0, 1'b1, 4'h0, "R10");
    // R6 R7: shifts with pin inputs set
    step(10'b1000_011_100, 6'd1, 6'd0, 16'h0, 1'b0, 1'b1, 4'h0, "R6");
    step(10'b1110_011_100, 6'd1, 6'd3, 16'h0, 1'b0, 1'b1, 4'b1010, "R7");
    step(10'b1100_011_100, 6'd3, 6'd4, 16'h0, 1'b0, 1'b1, 4'b0101, "R7");
    step(10'b1001_011_010, 6'd4, 6'd0, 16'h0, 1'b0, 1'b1, 4'h0, "R6");
    // R9: output disabled
    step(10'b1011_011_100, 6'd1, 6'd6, 16'h0, 1'b0, 1'b0, 4'h0, "R9");
    // R2 R6 R8: random sweep
    for (int k = 0; k < 4000; k++) begin
      step(10'($urandom), 6'($urandom), 6'($urandom), 16'($urandom),
           1'($urandom), ($urandom % 8) != 0, 4'($urandom), "R2 R6 R8");
    end
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule